// File: doc/BRIEF.md
# Shifting Load-Align Register Unit

This block holds a 64-bit destination register pair that behaves as a sliding window over a stream of loaded memory elements. On every accepted load the current contents move toward the least-significant end by the width of the access, one byte or one halfword. The freshly fetched element then fills the vacated most-significant bits. A run of narrow loads therefore builds a wide value from the top down. The oldest data falls out of the bottom and the newest sits at the top.

The loaded data arrives already fetched on a 16-bit little-endian bus. Address generation, the memory and instruction decode all live outside the block. The only decode done here is on a 4-bit minor opcode, which picks the byte variant or the halfword variant. A separate write port presets the register to any starting value, for example all ones, before a sequence of loads. The register value is driven straight from a flop, so a load's effect shows on the output one clock after the edge that accepts it.

Top module: `lalign_unit`

## Requirements
- R1: While the active-low reset `rst_n` is low, and after it is released, the register reads all zeros until the first write or load.
- R2: With `ld_valid` high and `ld_op` equal to 4'b0100 (byte), the next value is the old value logically shifted right by 8, with `ld_data[7:0]` in bits [63:56].
- R3: With `ld_valid` high and `ld_op` equal to 4'b0010 (halfword), the next value is the old value shifted right by 16, with `ld_data[7:0]` (the lower-address byte) in bits [55:48] and `ld_data[15:8]` in bits [63:56].
- R4: A byte load is zero-extended before insertion. `ld_data[15:8]` has no effect on the result of a byte load.
- R5: With `ld_valid` high and any other `ld_op` value, the register keeps its value.
- R6: With `ld_valid` low and `init_we` low, the register keeps its value whatever `ld_op` and `ld_data` carry.
- R7: With `init_we` high, the next value is `init_data`, even if a load is presented in the same cycle.
- R8: Each update is visible on `win_q` in the cycle after the accepting edge. Successive loads accumulate. Starting from all ones, bytes 01,02,03,04 give 0x04030201ffffffff, and halfwords over memory bytes 01..08 give 0x0807060504030201.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ld_valid | input | 1 | Load strobe for this cycle |
| ld_op | input | 4 | Minor opcode: 4'b0100 byte, 4'b0010 halfword, other values no operation |
| ld_data | input | 16 | Fetched data, little-endian: [7:0] is the lower address |
| init_we | input | 1 | Preset strobe, takes priority over a load |
| init_data | input | 64 | Preset value |
| win_q | output | 64 | Current register pair value |

## Verification
A wrong shift amount or a wrong insert position corrupts `win_q` on the very next cycle. The error stays visible, because later loads only push the corrupt bytes toward the bottom and do not remove them until four or eight more loads. A decode fault that updates on an unknown opcode or an idle cycle shows at once as a changed output where a stable one is expected. The opcode sweep runs every opcode against many preset patterns, so an error on any single code value cannot hide. A byte-lane swap in halfword loads shows as the reversed pair in bits [63:48].

// File: rtl/lalign_pkg.sv
package lalign_pkg;
  localparam int unsigned OPC_W = 4;
  localparam logic [OPC_W-1:0] OPC_HALF = 4'b0010;
  localparam logic [OPC_W-1:0] OPC_BYTE = 4'b0100;
endpackage

// File: rtl/lalign_rst_sync.sv
module lalign_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_q_n = sync_q[STAGES-1];
endmodule

// File: rtl/lalign_decode.sv
module lalign_decode
  import lalign_pkg::*;
#(
  parameter int unsigned MAX_ELEMS = 2,
  localparam int unsigned CNT_W = $clog2(MAX_ELEMS + 1)
) (
  input  logic             ld_valid,
  input  logic [OPC_W-1:0] ld_op,
  output logic [CNT_W-1:0] n_elems
);
  // Number of element slots the window advances; zero means no load.
  always_comb begin
    n_elems = '0;
    if (ld_valid) begin
      unique case (ld_op)
        OPC_BYTE: n_elems = CNT_W'(1);
        OPC_HALF: n_elems = CNT_W'(2);
        default:  n_elems = '0;
      endcase
    end
  end
endmodule

// File: rtl/lalign_merge.sv
module lalign_merge #(
  parameter int unsigned REG_W     = 64,
  parameter int unsigned ELEM_W    = 8,
  parameter int unsigned MAX_ELEMS = 2,
  localparam int unsigned DATA_W = ELEM_W * MAX_ELEMS,
  localparam int unsigned CNT_W  = $clog2(MAX_ELEMS + 1)
) (
  input  logic [REG_W-1:0]  old_q,
  input  logic [DATA_W-1:0] ld_data,
  input  logic [CNT_W-1:0]  n_elems,
  output logic [REG_W-1:0]  new_q
);
  logic [REG_W-1:0] cand [MAX_ELEMS+1];

  assign cand[0] = old_q;

  // One candidate per access width: drop k low elements, insert k new ones on top.
  for (genvar k = 1; k <= MAX_ELEMS; k++) begin : g_width
    assign cand[k] = {ld_data[k*ELEM_W-1:0], old_q[REG_W-1:k*ELEM_W]};
  end

  always_comb begin
    new_q = cand[0];
    for (int k = 1; k <= MAX_ELEMS; k++) begin
      if (n_elems == CNT_W'(k)) new_q = cand[k];
    end
  end
endmodule

// File: rtl/lalign_unit.sv
module lalign_unit
  import lalign_pkg::*;
#(
  parameter int unsigned REG_W     = 64,
  parameter int unsigned ELEM_W    = 8,
  parameter int unsigned MAX_ELEMS = 2,
  localparam int unsigned DATA_W = ELEM_W * MAX_ELEMS,
  localparam int unsigned CNT_W  = $clog2(MAX_ELEMS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic [OPC_W-1:0]  ld_op,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              init_we,
  input  logic [REG_W-1:0]  init_data,
  output logic [REG_W-1:0]  win_q
);
  logic             rst_q_n;
  logic [CNT_W-1:0] n_elems;
  logic [REG_W-1:0] merged;
  logic [REG_W-1:0] win_nxt;
  logic             win_en;

  lalign_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  lalign_decode #(.MAX_ELEMS(MAX_ELEMS)) decode_i (
    .ld_valid (ld_valid),
    .ld_op    (ld_op),
    .n_elems  (n_elems)
  );

  lalign_merge #(
    .REG_W     (REG_W),
    .ELEM_W    (ELEM_W),
    .MAX_ELEMS (MAX_ELEMS)
  ) merge_i (
    .old_q   (win_q),
    .ld_data (ld_data),
    .n_elems (n_elems),
    .new_q   (merged)
  );

  // Next-state: preset wins over a load.
  always_comb begin
    win_en  = init_we || (n_elems != '0);
    win_nxt = init_we ? init_data : merged;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)    win_q <= '0;
    else if (win_en) win_q <= win_nxt;
  end

  // R2
  byte_ins_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ld_valid && !init_we && ld_op == OPC_BYTE) |=>
      win_q == {$past(ld_data[ELEM_W-1:0]), $past(win_q[REG_W-1:ELEM_W])});

  if (MAX_ELEMS >= 2) begin : g_half_chk
    // R3
    half_ins_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
      (ld_valid && !init_we && ld_op == OPC_HALF) |=>
        win_q == {$past(ld_data[2*ELEM_W-1:0]), $past(win_q[REG_W-1:2*ELEM_W])});
  end

  // R5
  bad_op_hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ld_valid && !init_we && ld_op != OPC_BYTE && ld_op != OPC_HALF) |=> $stable(win_q));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!ld_valid && !init_we) |=> $stable(win_q));

  // R7
  init_prio_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    init_we |=> win_q == $past(init_data));
endmodule

// File: tb/lalign_unit_tb.sv
module lalign_unit_tb_top;
  localparam int CLK_P = 10;

  logic        clk;
  logic        rst_n;
  logic        ld_valid;
  logic [3:0]  ld_op;
  logic [15:0] ld_data;
  logic        init_we;
  logic [63:0] init_data;
  logic [63:0] win_q;

  int checks;
  int failures;
  logic [63:0] model;

  lalign_unit dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_valid  (ld_valid),
    .ld_op     (ld_op),
    .ld_data   (ld_data),
    .init_we   (init_we),
    .init_data (init_data),
    .win_q     (win_q)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  function automatic logic [63:0] expect_next(logic [63:0] q, logic v, logic [3:0] op,
                                              logic [15:0] d, logic iw, logic [63:0] id);
    if (iw) return id;
    if (!v) return q;
    if (op == 4'b0100) return (q >> 8) | ({56'd0, d[7:0]} << 56);
    if (op == 4'b0010) return (q >> 16) | ({48'd0, d} << 48);
    return q;
  endfunction

  function automatic logic [63:0] pattern(int s);
    logic [31:0] a, b;
    a = 32'(s) * 32'h9E3779B1 + 32'h1234567;
    b = ~32'(s) * 32'h85EBCA6B;
    return {a, b};
  endfunction

  task automatic check(string req, logic [63:0] exp);
    checks++;
    if (win_q !== exp) begin
      failures++;
      $display("FAIL %s actual=%016h expected=%016h", req, win_q, exp);
    end
  endtask

  // Drive at negedge, let one posedge pass, sample at the following negedge.
  task automatic step(string req, logic v, logic [3:0] op, logic [15:0] d,
                      logic iw, logic [63:0] id);
    ld_valid = v; ld_op = op; ld_data = d; init_we = iw; init_data = id;
    model = expect_next(model, v, op, d, iw, id);
    @(posedge clk);
    @(negedge clk);
    ld_valid = 1'b0; init_we = 1'b0;
    check(req, model);
  endtask

  initial begin
    #(CLK_P * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks = 0; failures = 0; model = '0;
    rst_n = 1'b0; ld_valid = 1'b0; ld_op = '0; ld_data = '0;
    init_we = 1'b0; init_data = '0;
    repeat (3) @(negedge clk);
    check("R1 during reset", 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after release", 64'd0);

    // R8 byte sequence from all ones (R2)
    step("R7 preset", 1'b0, 4'h0, 16'h0, 1'b1, '1);
    for (int i = 1; i <= 4; i++) step("R2 R8 byte seq", 1'b1, 4'b0100, 16'(i), 1'b0, '0);
    check("R8 byte seq end", 64'h04030201ffffffff);

    // R8 halfword sequence over memory bytes 01..08 (R3)
    step("R7 preset", 1'b0, 4'h0, 16'h0, 1'b1, '1);
    for (int i = 0; i < 4; i++)
      step("R3 R8 half seq", 1'b1, 4'b0010, {8'(2*i+2), 8'(2*i+1)}, 1'b0, '0);
    check("R8 half seq end", 64'h0807060504030201);

    // R4: upper bus byte ignored on byte loads
    step("R7 preset", 1'b0, 4'h0, 16'h0, 1'b1, 64'h0);
    step("R4 zero-extend", 1'b1, 4'b0100, 16'hAB5C, 1'b0, '0);
    check("R4 literal", 64'h5C00000000000000);

    // R7: preset wins over simultaneous load
    step("R7 priority", 1'b1, 4'b0010, 16'hFFFF, 1'b1, 64'h0123456789ABCDEF);
    check("R7 literal", 64'h0123456789ABCDEF);

    // Sweep every opcode against many patterns, loaded and idle
    for (int op = 0; op < 16; op++) begin
      for (int t = 0; t < 16; t++) begin
        logic [63:0] p;
        logic [15:0] d;
        p = pattern(op * 16 + t);
        d = 16'(p[47:32] ^ 16'(t * 16'h3B1));
        step("R7 sweep preset", 1'b0, 4'(op), d, 1'b1, p);
        step("R6 idle hold", 1'b0, 4'(op), ~d, 1'b0, ~p);
        if (op == 4) step("R2 sweep byte", 1'b1, 4'(op), d, 1'b0, '0);
        else if (op == 2) step("R3 sweep half", 1'b1, 4'(op), d, 1'b0, '0);
        else step("R5 other opcode hold", 1'b1, 4'(op), d, 1'b0, '0);
      end
    end

    // R1: asynchronous reset mid-run clears the register
    step("R7 preset", 1'b0, 4'h0, 16'h0, 1'b1, '1);
    rst_n = 1'b0;
    #1;
    model = '0;
    check("R1 async clear", 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after second release", 64'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule